// File: doc/BRIEF.md
# External Memory Strobe Timing Engine

This block runs one asynchronous external-memory access. A start pulse opens the access and a direction flag chooses read or write. The block then counts functional-clock ticks from zero. Four active-low strobes are each placed on that count at programmed tick values: chip select, address valid, output enable and write enable. The read-data capture pulse and the end-of-access pulse are placed the same way. All tick values come from five packed 32-bit configuration words, which must be held stable while an access runs.

The configuration can select synchronous mode for reads or for writes. When the running direction uses synchronous mode, the block also emits a bus-clock tick. This tick marks each rising edge of an external clock that runs at the functional clock divided by 1 to 4.

The start, direction and result pins are plain control pulses with no handshake. A start that arrives while an access is running is dropped. The caller watches the done pulse before it issues the next access.

Top module: `xmem_strobe_timer`

## Requirements
- R1: After reset, all four strobes are high (deasserted), and done, capture and bus-clock tick are low.
- R2: A start sampled high while idle begins an access. The direction flag (1 = write) is latched on the same edge. Tick 0 is the cycle after that edge, and the tick count rises by one each cycle.
- R3: Chip select (`cs_n`) is low on ticks t where on <= t < off. The on-time is in cfg2[3:0]. The off-time is cfg2[12:8] for reads and cfg2[20:16] for writes.
- R4: Address valid (`adv_n`) follows the same rule. Its on-time is in cfg3[3:0]. Its off-time is cfg3[12:8] for reads and cfg3[20:16] for writes.
- R5: Output enable (`oe_n`) is low only during reads, on ticks with cfg4[3:0] <= t < cfg4[12:8].
- R6: Write enable (`we_n`) is low only during writes, on ticks with cfg4[19:16] <= t < cfg4[28:24].
- R7: `done_o` is high for exactly one cycle, on the tick equal to the cycle length. The length is cfg5[4:0] for reads and cfg5[12:8] for writes. On the following cycle the engine is idle with all strobes high.
- R8: `capture_o` is high for one cycle, during reads only, on the tick equal to cfg5[20:16]. If that value exceeds the read length, there is no pulse.
- R9: A start while an access runs, including on its done tick, is ignored. The running access keeps its timing, and no second access follows.
- R10: Synchronous reads are selected by cfg1[8] and synchronous writes by cfg1[9]. cfg1[1:0] holds the divide ratio minus one, giving N from 1 to 4. If the running direction is synchronous, `bus_clk_tick_o` is high on ticks 0, N, 2N and so on, up to the done tick. Otherwise it stays low.
- R11: A strobe whose on-time is at or above its off-time never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Access request pulse |
| is_write_i | input | 1 | Direction, 1 = write, sampled with start |
| cfg1_i | input | 32 | Divider and synchronous-mode selects |
| cfg2_i | input | 32 | Chip-select timing |
| cfg3_i | input | 32 | Address-valid timing |
| cfg4_i | input | 32 | Output/write-enable timing |
| cfg5_i | input | 32 | Cycle lengths and access time |
| cs_n_o | output | 1 | Chip select, active low |
| adv_n_o | output | 1 | Address valid, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| capture_o | output | 1 | Read data capture pulse |
| done_o | output | 1 | End-of-access pulse |
| bus_clk_tick_o | output | 1 | External clock rising-edge marker |

## Verification
The only register between the start edge and the outputs is the tick counter. Every output therefore depends on tick t during the (t+1)-th cycle after the edge that sampled start, and idle follows one cycle after done. The bench drives inputs on falling edges and checks all seven outputs on every falling edge from tick 0 through the idle cycle after done. Expected values come from window arithmetic on the programmed fields. The sweep covers many field combinations in both directions and all four divide ratios, and on some runs it issues extra starts mid-access and on the done tick.

// File: rtl/xmt_pkg.sv
package xmt_pkg;
  localparam int CNT_W = 5;
  localparam int ON_W  = 4;

  typedef struct packed {
    logic [ON_W-1:0]  on_t;
    logic [CNT_W-1:0] rd_off;
    logic [CNT_W-1:0] wr_off;
  } win_cfg_t;

  function automatic win_cfg_t unpack_win(input logic [31:0] w);
    win_cfg_t r;
    r.on_t   = w[3:0];
    r.rd_off = w[12:8];
    r.wr_off = w[20:16];
    return r;
  endfunction
endpackage

// File: rtl/xmt_tick_counter.sv
module xmt_tick_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic [CNT_W-1:0] rd_len_i,
  input  logic [CNT_W-1:0] wr_len_i,
  output logic             busy_o,
  output logic             dir_wr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] len;

  assign len    = dir_wr_o ? wr_len_i : rd_len_i;
  assign done_o = busy_o && (cnt_o == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      dir_wr_o <= 1'b0;
      cnt_o    <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o   <= 1'b1;
        dir_wr_o <= is_write_i;
        cnt_o    <= '0;
      end
    end else if (done_o) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // R9: while an access runs, the count only advances, whatever start does
  p_count_advances_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> (busy_o && cnt_o == $past(cnt_o) + 1'b1));
  // R7: done lasts one cycle and the engine is idle afterwards
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));
  // R2: an idle start opens an access at tick 0
  p_start_tick0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && cnt_o == '0));
endmodule

// File: rtl/xmt_strobe_window.sv
module xmt_strobe_window #(
  parameter int CNT_W = 5,
  parameter int ON_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             allow_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [ON_W-1:0]  on_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             strobe_n_o
);
  logic in_win;

  assign in_win     = (cnt_i >= CNT_W'(on_i)) && (cnt_i < off_i);
  assign strobe_n_o = !(busy_i && allow_i && in_win);

  // R11: a window with on >= off never opens
  p_empty_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(on_i) >= off_i) |-> strobe_n_o);
endmodule

// File: rtl/xmt_bus_clk_div.sv
module xmt_bus_clk_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             sync_i,
  input  logic [DIV_W-1:0] div_m1_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!busy_i || phase == div_m1_i) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign tick_o = busy_i && sync_i && (phase == '0);

  // R10: with a ratio above one, ticks are never adjacent
  p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_m1_i != '0 && $stable(div_m1_i)) |=> !tick_o);
endmodule

// File: rtl/xmem_strobe_timer.sv
module xmem_strobe_timer
  import xmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        is_write_i,
  input  logic [31:0] cfg1_i,
  input  logic [31:0] cfg2_i,
  input  logic [31:0] cfg3_i,
  input  logic [31:0] cfg4_i,
  input  logic [31:0] cfg5_i,
  output logic        cs_n_o,
  output logic        adv_n_o,
  output logic        oe_n_o,
  output logic        we_n_o,
  output logic        capture_o,
  output logic        done_o,
  output logic        bus_clk_tick_o
);
  localparam int NSTB = 4;

  logic             busy, dir_wr;
  logic [CNT_W-1:0] cnt;
  win_cfg_t         cs_w, adv_w;
  logic [ON_W-1:0]  on_v  [NSTB];
  logic [CNT_W-1:0] off_v [NSTB];
  logic [NSTB-1:0]  allow_v, stb_n;

  assign cs_w  = unpack_win(cfg2_i);
  assign adv_w = unpack_win(cfg3_i);

  assign on_v[0]  = cs_w.on_t;
  assign off_v[0] = dir_wr ? cs_w.wr_off : cs_w.rd_off;
  assign allow_v[0] = 1'b1;
  assign on_v[1]  = adv_w.on_t;
  assign off_v[1] = dir_wr ? adv_w.wr_off : adv_w.rd_off;
  assign allow_v[1] = 1'b1;
  assign on_v[2]  = cfg4_i[3:0];
  assign off_v[2] = cfg4_i[12:8];
  assign allow_v[2] = !dir_wr;
  assign on_v[3]  = cfg4_i[19:16];
  assign off_v[3] = cfg4_i[28:24];
  assign allow_v[3] = dir_wr;

  xmt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .is_write_i (is_write_i),
    .rd_len_i   (cfg5_i[4:0]),
    .wr_len_i   (cfg5_i[12:8]),
    .busy_o     (busy),
    .dir_wr_o   (dir_wr),
    .cnt_o      (cnt),
    .done_o     (done_o)
  );

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    xmt_strobe_window #(.CNT_W(CNT_W), .ON_W(ON_W)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy),
      .allow_i    (allow_v[g]),
      .cnt_i      (cnt),
      .on_i       (on_v[g]),
      .off_i      (off_v[g]),
      .strobe_n_o (stb_n[g])
    );
  end

  assign cs_n_o  = stb_n[0];
  assign adv_n_o = stb_n[1];
  assign oe_n_o  = stb_n[2];
  assign we_n_o  = stb_n[3];

  assign capture_o = busy && !dir_wr && (cnt == cfg5_i[20:16]);

  xmt_bus_clk_div #(.DIV_W(2)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_i   (busy),
    .sync_i   (dir_wr ? cfg1_i[9] : cfg1_i[8]),
    .div_m1_i (cfg1_i[1:0]),
    .tick_o   (bus_clk_tick_o)
  );

  // R7: every strobe is released on the cycle after done
  p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (cs_n_o && adv_n_o && oe_n_o && we_n_o && !capture_o));
  // R5/R6: output enable and write enable are never low together
  p_oe_we_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n_o && !we_n_o));
  // R8: capture only happens in a read, so write enable stays high
  p_capture_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |-> we_n_o);
endmodule

// File: tb/xmem_strobe_timer_tb.sv
module xmem_strobe_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, start_i = 0, is_write_i = 0;
  logic [31:0] cfg1_i = 0, cfg2_i = 0, cfg3_i = 0, cfg4_i = 0, cfg5_i = 0;
  logic        cs_n_o, adv_n_o, oe_n_o, we_n_o, capture_o, done_o, bus_clk_tick_o;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  int cs_on, cs_rd, cs_wr, adv_on, adv_rd, adv_wr, oe_on, oe_off, we_on, we_off;
  int rd_len, wr_len, acc, dm1, s_rd, s_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_strobe_timer u_dut (.*);

  task automatic chk(input string req, input logic act, input logic exp, input int t);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s tick %0d: actual %b expected %b", req, t, act, exp);
    end
  endtask

  task automatic load_cfg();
    cfg1_i = {22'd0, 1'(s_wr), 1'(s_rd), 6'd0, 2'(dm1)};
    cfg2_i = {11'd0, 5'(cs_wr), 3'd0, 5'(cs_rd), 4'd0, 4'(cs_on)};
    cfg3_i = {11'd0, 5'(adv_wr), 3'd0, 5'(adv_rd), 4'd0, 4'(adv_on)};
    cfg4_i = {3'd0, 5'(we_off), 4'd0, 4'(we_on), 3'd0, 5'(oe_off), 4'd0, 4'(oe_on)};
    cfg5_i = {11'd0, 5'(acc), 3'd0, 5'(wr_len), 3'd0, 5'(rd_len)};
  endtask

  task automatic idle_chk(input string req);
    chk({req, " cs_n idle"}, cs_n_o, 1'b1, -1);
    chk({req, " adv_n idle"}, adv_n_o, 1'b1, -1);
    chk({req, " oe_n idle"}, oe_n_o, 1'b1, -1);
    chk({req, " we_n idle"}, we_n_o, 1'b1, -1);
    chk({req, " done idle"}, done_o, 1'b0, -1);
    chk({req, " capture idle"}, capture_o, 1'b0, -1);
    chk({req, " tick idle"}, bus_clk_tick_o, 1'b0, -1);
  endtask

  // Runs one access; with poke set, extra starts come mid-access and on done (R9)
  task automatic run_access(input bit wr, input bit poke);
    int len, coff, aoff, n;
    bit syn;
    len  = wr ? wr_len : rd_len;
    coff = wr ? cs_wr : cs_rd;
    aoff = wr ? adv_wr : adv_rd;
    syn  = wr ? s_wr[0] : s_rd[0];
    n    = dm1 + 1;
    @(negedge clk);
    start_i = 1; is_write_i = wr;
    @(negedge clk);
    start_i = 0; is_write_i = ~wr;
    for (int t = 0; t <= len; t++) begin
      chk("R3 cs_n", cs_n_o, !(t >= cs_on && t < coff), t);
      chk("R4 adv_n", adv_n_o, !(t >= adv_on && t < aoff), t);
      chk("R5 oe_n", oe_n_o, !(!wr && t >= oe_on && t < oe_off), t);
      chk("R6 we_n", we_n_o, !(wr && t >= we_on && t < we_off), t);
      chk("R7 done", done_o, t == len, t);
      chk("R8 capture", capture_o, !wr && t == acc, t);
      chk("R10 bus tick", bus_clk_tick_o, syn && (t % n) == 0, t);
      if (poke && (t == 1 || t == len)) start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    idle_chk("R7 after done");
    @(negedge clk);
    idle_chk("R9 no restart");
  endtask

  initial begin : stim
    #(CLK_PERIOD * 2 + 3);
    idle_chk("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    idle_chk("R1 after reset");
    for (int i = 0; i < 64; i++) begin
      cs_on  = i % 5;        cs_rd  = (i * 3) % 9;  cs_wr  = (i * 5) % 9;
      adv_on = (i + 1) % 4;  adv_rd = (i * 7) % 10; adv_wr = (i * 2) % 8;
      oe_on  = i % 3;        oe_off = (i * 4) % 9 + 1;
      we_on  = (i + 2) % 4;  we_off = (i * 3) % 7 + 2;
      rd_len = i % 9;        wr_len = (i * 5) % 9;
      acc    = (i * 2) % 11; dm1 = i % 4;
      s_rd   = (i >> 1) & 1; s_wr = (i >> 2) & 1;
      if (i == 63) begin
        rd_len = 31; wr_len = 31; cs_rd = 31; cs_wr = 31; cs_on = 15;
        we_on = 15; we_off = 31; oe_on = 15; oe_off = 31; acc = 30; s_rd = 1; s_wr = 1;
      end
      load_cfg();
      run_access(1'b0, i[0]);
      run_access(1'b1, i[0]);
    end
    finished = 1;
  end

  initial begin : watchdog
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule